// File: doc/BRIEF.md
# Memory-Mapped Single-Select SPI Master

This block is a serial peripheral interface master sitting behind a flat 32-bit register bus. Software programs a word size (8 or 16 bits) and a clock ratio, drives the single chip-select line directly through a control bit, and starts one full-duplex exchange by writing the word to send. The serial clock runs in mode 0: it rests low, the outgoing bit is placed while the clock is low, and the incoming bit is captured on each rising edge. Bits leave and arrive most significant first, and a 16-bit word goes out as one unbroken run of 16 clocks.

The serial clock is derived from the system clock by a 5-bit offset-coded prescale field. A field whose top bit is set and whose low four bits hold H (2 to 15) gives a serial period of N = 2*H system clocks, so N covers the even values 4 to 30. When the last bit has been exchanged the received word is latched into a read-only register and a sticky completion cause is raised. The cause stays set until software writes zero to it.

Top module: `mmio_spi_master`

## Requirements
- R1: After reset every register reads zero, cs_n is high, sclk is low and no exchange is in progress.
- R2: Bit 0 of the control register at offset 0x00 drives the select: writing 1 makes cs_n low on the next cycle, writing 0 makes it high. The bit reads back.
- R3: The configuration register at offset 0x04 stores bit 14 (a timing-adjust flag with no effect on the bus), bit 5 (word size, 1 = 16 bits, 0 = 8 bits) and bits 4:0 (prescale). All other bits read zero.
- R4: A write to offset 0x08 while idle starts one exchange of 8 or 16 sclk pulses, per configuration bit 5, shifting the low 8 or 16 bits of the written data out on mosi most significant bit first. The accepted word reads back from 0x08.
- R5: With prescale p, the sclk period is N = 2*p[3:0] system clocks when p[4] is 1 and p[3:0] is at least 2; in every other case N = 4. sclk is low whenever no exchange runs.
- R6: mosi only changes while sclk is low, and miso is sampled at each rising edge of sclk.
- R7: After completion the receive register at offset 0x0C holds the received bits zero-extended: the low 8 bits in 8-bit mode, the low 16 bits in 16-bit mode.
- R8: The cause register at offset 0x10 reads 1 starting exactly W*N system clocks after the starting write edge (W = word size). Writing 0 clears it; writing any nonzero value leaves it unchanged.
- R9: When completion and a write of 0 to the cause register fall on the same clock edge, the cause ends up set.
- R10: A write to offset 0x08 while an exchange runs is ignored: the running word, its length, its completion time and the transmit readback are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Chip select, active low |

## Verification
The completion of an exchange and a software write of zero to the cause register can land on the same clock edge. The bench computes that edge as W*N cycles after the starting write, places the clearing write exactly there, and then expects the cause to read 1, proving that set takes priority over clear; it also reads the cause one cycle before and one cycle after the computed edge to pin down that edge. A second overlap, a transmit write arriving while a word is shifting, is judged by the serial-pin scoreboard seeing only the first word and by the completion edge staying where the first write put it.

// File: rtl/spi_mm_pkg.sv
// Package: shared constants, register selector type and the prescale
// decoding used by the memory-mapped SPI master.
// Assumes a byte-addressed bus with word registers on 4-byte offsets.
package spi_mm_pkg;

    localparam int BUS_ADDR_W   = 5;
    localparam int BUS_DATA_W   = 32;
    localparam int SPI_WORD_W   = 16;
    localparam int SPI_NARROW_W = 8;
    localparam int PRESC_W      = 5;
    localparam int HALF_W       = PRESC_W - 1;

    // Register byte offsets
    localparam int OFS_CTRL  = 'h00;
    localparam int OFS_CFG   = 'h04;
    localparam int OFS_TX    = 'h08;
    localparam int OFS_RX    = 'h0C;
    localparam int OFS_CAUSE = 'h10;

    // Configuration bit positions
    localparam int CFG_WIDE_BIT = 5;
    localparam int CFG_TIM_BIT  = 14;

    // Smallest half period, in system clocks (ratio 4)
    localparam int HALF_MIN = 2;

    typedef enum logic [2:0] {
        SEL_CTRL,
        SEL_CFG,
        SEL_TX,
        SEL_RX,
        SEL_CAUSE,
        SEL_NONE
    } reg_sel_e;

    // Turn the offset-coded prescale field into a half period count.
    // Top bit clear, or a half period under the minimum, falls back to the minimum.
    function automatic logic [HALF_W-1:0] presc_to_half(input logic [PRESC_W-1:0] p);
        if (p[PRESC_W-1] && (p[HALF_W-1:0] >= HALF_W'(HALF_MIN)))
            return p[HALF_W-1:0];
        else
            return HALF_W'(HALF_MIN);
    endfunction

endpackage

// File: rtl/spi_mm_regs.sv
// Register file of the SPI master: address decode, write side effects,
// read multiplexer, receive latch and sticky completion cause.
// Assumes one-cycle write strobes and a combinational read path.
module spi_mm_regs
    import spi_mm_pkg::*;
#(
    parameter int ADDR_W   = BUS_ADDR_W,
    parameter int DATA_W   = BUS_DATA_W,
    parameter int WORD_W   = SPI_WORD_W,
    parameter int NARROW_W = SPI_NARROW_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                busy,
    input  logic                done,
    input  logic [WORD_W-1:0]   rx_word,
    output logic                start,
    output logic [WORD_W-1:0]   tx_word,
    output logic                wide,
    output logic [PRESC_W-1:0]  presc,
    output logic                cs_assert,
    output logic                cause
);

    localparam int PAD_W = WORD_W - NARROW_W;

    logic                ctrl_q;
    logic                cfg_wide_q;
    logic                cfg_tim_q;
    logic [PRESC_W-1:0]  cfg_presc_q;
    logic [WORD_W-1:0]   tx_q;
    logic [WORD_W-1:0]   rx_q;
    logic                cause_q;
    reg_sel_e            sel;
    logic                wr_ctrl, wr_cfg, wr_tx, wr_cause;
    logic [WORD_W-1:0]   rx_masked;

    // Decode the bus offset into a register selector
    always_comb begin
        if      (bus_addr == ADDR_W'(OFS_CTRL))  sel = SEL_CTRL;
        else if (bus_addr == ADDR_W'(OFS_CFG))   sel = SEL_CFG;
        else if (bus_addr == ADDR_W'(OFS_TX))    sel = SEL_TX;
        else if (bus_addr == ADDR_W'(OFS_RX))    sel = SEL_RX;
        else if (bus_addr == ADDR_W'(OFS_CAUSE)) sel = SEL_CAUSE;
        else                                     sel = SEL_NONE;
    end

    // Per-register write strobes
    always_comb begin
        wr_ctrl  = bus_wr && (sel == SEL_CTRL);
        wr_cfg   = bus_wr && (sel == SEL_CFG);
        wr_tx    = bus_wr && (sel == SEL_TX);
        wr_cause = bus_wr && (sel == SEL_CAUSE);
    end

    // A transmit write only starts a word when the engine is idle
    assign start = wr_tx && !busy;

    // Keep only the meaningful received bits for the current word size
    generate
        if (PAD_W > 0) begin : g_rx_pad
            assign rx_masked = cfg_wide_q ? rx_word
                                          : {{PAD_W{1'b0}}, rx_word[NARROW_W-1:0]};
        end else begin : g_rx_nopad
            assign rx_masked = rx_word;
        end
    endgenerate

    // Control register: select drive bit
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= 1'b0;
        else if (wr_ctrl) ctrl_q <= bus_wdata[0];
    end

    // Configuration register: word size, timing flag and prescale
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_wide_q  <= 1'b0;
            cfg_tim_q   <= 1'b0;
            cfg_presc_q <= '0;
        end else if (wr_cfg) begin
            cfg_wide_q  <= bus_wdata[CFG_WIDE_BIT];
            cfg_tim_q   <= bus_wdata[CFG_TIM_BIT];
            cfg_presc_q <= bus_wdata[PRESC_W-1:0];
        end
    end

    // Transmit readback: last word that actually started an exchange
    always_ff @(posedge clk) begin
        if (!rst_n)     tx_q <= '0;
        else if (start) tx_q <= bus_wdata[WORD_W-1:0];
    end

    // Receive latch: captured on the completion cycle
    always_ff @(posedge clk) begin
        if (!rst_n)    rx_q <= '0;
        else if (done) rx_q <= rx_masked;
    end

    // Completion cause: set by completion, cleared by writing zero, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)                              cause_q <= 1'b0;
        else if (done)                           cause_q <= 1'b1;
        else if (wr_cause && (bus_wdata == '0))  cause_q <= 1'b0;
    end

    // Read multiplexer
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_CTRL:  bus_rdata[0] = ctrl_q;
            SEL_CFG: begin
                bus_rdata[CFG_TIM_BIT]   = cfg_tim_q;
                bus_rdata[CFG_WIDE_BIT]  = cfg_wide_q;
                bus_rdata[PRESC_W-1:0]   = cfg_presc_q;
            end
            SEL_TX:    bus_rdata = DATA_W'(tx_q);
            SEL_RX:    bus_rdata = DATA_W'(rx_q);
            SEL_CAUSE: bus_rdata[0] = cause_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign tx_word   = bus_wdata[WORD_W-1:0];
    assign wide      = cfg_wide_q;
    assign presc     = cfg_presc_q;
    assign cs_assert = ctrl_q;
    assign cause     = cause_q;

endmodule

// File: rtl/spi_mm_clkdiv.sv
// Half-period timer: while run is high, pulses tick once every `half`
// system clocks; each tick marks one serial clock edge.
// Assumes half is at least 1 and held stable while run is high.
module spi_mm_clkdiv #(
    parameter int HALF_W = spi_mm_pkg::HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] half,
    output logic              tick
);

    logic [HALF_W-1:0] cnt_q;
    logic              at_end;

    assign at_end = (cnt_q == (half - HALF_W'(1)));
    assign tick   = run && at_end;

    // Count system clocks within one half period, parked at zero when idle
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (at_end)    cnt_q <= '0;
        else                cnt_q <= cnt_q + HALF_W'(1);
    end

endmodule

// File: rtl/spi_mm_shift.sv
// Mode-0 shift engine: on start loads the word (left-aligned when narrow),
// toggles sclk on each tick, samples miso on rising edges and advances
// mosi on falling edges. done is high in the cycle before the final
// falling edge takes effect.
// Assumes start is only raised while busy is low.
module spi_mm_shift #(
    parameter int WORD_W   = spi_mm_pkg::SPI_WORD_W,
    parameter int NARROW_W = spi_mm_pkg::SPI_NARROW_W,
    parameter int HALF_W   = spi_mm_pkg::HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wide,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [HALF_W-1:0] half_in,
    input  logic              tick,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic [HALF_W-1:0] half_q
);

    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam int PAD_W = WORD_W - NARROW_W;

    logic [WORD_W-1:0] tx_sh;
    logic [WORD_W-1:0] rx_sh;
    logic [CNT_W-1:0]  bits_left;
    logic              sclk_q;
    logic              busy_q;
    logic [WORD_W-1:0] tx_load;
    logic              last_fall;

    // Align a narrow word to the top so the first bit is always the MSB
    generate
        if (PAD_W > 0) begin : g_align
            assign tx_load = wide ? tx_word
                                  : {tx_word[NARROW_W-1:0], {PAD_W{1'b0}}};
        end else begin : g_noalign
            assign tx_load = tx_word;
        end
    endgenerate

    assign last_fall = busy_q && tick && sclk_q && (bits_left == CNT_W'(1));

    // Exchange sequencer: load, toggle, sample on rise, shift on fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q    <= 1'b0;
            sclk_q    <= 1'b0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            bits_left <= '0;
            half_q    <= HALF_W'(spi_mm_pkg::HALF_MIN);
        end else if (start && !busy_q) begin
            busy_q    <= 1'b1;
            sclk_q    <= 1'b0;
            tx_sh     <= tx_load;
            rx_sh     <= '0;
            bits_left <= wide ? CNT_W'(WORD_W) : CNT_W'(NARROW_W);
            half_q    <= half_in;
        end else if (busy_q && tick) begin
            sclk_q <= !sclk_q;
            if (!sclk_q) begin
                rx_sh <= {rx_sh[WORD_W-2:0], miso};
            end else if (last_fall) begin
                busy_q <= 1'b0;
            end else begin
                tx_sh     <= {tx_sh[WORD_W-2:0], 1'b0};
                bits_left <= bits_left - CNT_W'(1);
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = tx_sh[WORD_W-1];
    assign busy    = busy_q;
    assign done    = last_fall;
    assign rx_word = rx_sh;

endmodule

// File: rtl/mmio_spi_master.sv
// Top level of the memory-mapped single-select SPI master: joins the
// register file, the half-period timer and the mode-0 shift engine.
// Assumes a single system clock and synchronous active-low reset.
module mmio_spi_master
    import spi_mm_pkg::*;
#(
    parameter int ADDR_W   = BUS_ADDR_W,
    parameter int DATA_W   = BUS_DATA_W,
    parameter int WORD_W   = SPI_WORD_W,
    parameter int NARROW_W = SPI_NARROW_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);

    logic                busy_w;
    logic                done_w;
    logic                start_w;
    logic                wide_w;
    logic                cs_on_w;
    logic                cause_w;
    logic                tick_w;
    logic [WORD_W-1:0]   tx_w;
    logic [WORD_W-1:0]   rx_w;
    logic [PRESC_W-1:0]  presc_w;
    logic [HALF_W-1:0]   half_dec_w;
    logic [HALF_W-1:0]   half_run_w;

    // Decode the prescale field into a half period
    assign half_dec_w = presc_to_half(presc_w);

    // Select is driven only by software
    assign cs_n = !cs_on_w;

    spi_mm_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .WORD_W   (WORD_W),
        .NARROW_W (NARROW_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .busy      (busy_w),
        .done      (done_w),
        .rx_word   (rx_w),
        .start     (start_w),
        .tx_word   (tx_w),
        .wide      (wide_w),
        .presc     (presc_w),
        .cs_assert (cs_on_w),
        .cause     (cause_w)
    );

    spi_mm_clkdiv #(
        .HALF_W (HALF_W)
    ) u_clkdiv (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_w),
        .half  (half_run_w),
        .tick  (tick_w)
    );

    spi_mm_shift #(
        .WORD_W   (WORD_W),
        .NARROW_W (NARROW_W),
        .HALF_W   (HALF_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start_w),
        .wide    (wide_w),
        .tx_word (tx_w),
        .half_in (half_dec_w),
        .tick    (tick_w),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .busy    (busy_w),
        .done    (done_w),
        .rx_word (rx_w),
        .half_q  (half_run_w)
    );

endmodule

// File: rtl/mmio_spi_master_chk.sv
// Checker for the SPI master: temporal properties over the bus, the
// serial pins and the engine's busy/done/cause signals.
// Assumes it is attached to the top through the bind below.
module mmio_spi_master_chk
    import spi_mm_pkg::*;
#(
    parameter int ADDR_W = BUS_ADDR_W,
    parameter int DATA_W = BUS_DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              sclk,
    input logic              mosi,
    input logic              cs_n,
    input logic              busy,
    input logic              done,
    input logic              cause
);

    logic wr_ctrl_c, wr_tx_c, clr_cause_c;

    assign wr_ctrl_c   = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));
    assign wr_tx_c     = bus_wr && (bus_addr == ADDR_W'(OFS_TX));
    assign clr_cause_c = bus_wr && (bus_addr == ADDR_W'(OFS_CAUSE)) && (bus_wdata == '0);

    AST_CS_FOLLOWS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl_c |=> (cs_n == !$past(bus_wdata[0])));                 // R2

    AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);                                              // R5

    AST_MOSI_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(mosi));                                       // R6

    AST_CAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (cause && !clr_cause_c) |=> cause);                            // R8

    AST_DONE_SETS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cause);                                               // R9

    AST_BUSY_TX_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && wr_tx_c) |=> busy);                          // R10

endmodule

bind mmio_spi_master mmio_spi_master_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .sclk      (sclk),
    .mosi      (mosi),
    .cs_n      (cs_n),
    .busy      (busy_w),
    .done      (done_w),
    .cause     (cause_w)
);

// File: tb/test_mmio_spi_master.sv
// Scoreboard bench: the driver pushes each expected serial word, the
// monitor on sclk compares the shifted word and the serial period.
module test_mmio_spi_master;

    localparam logic [4:0] A_CTRL  = 5'h00;
    localparam logic [4:0] A_CFG   = 5'h04;
    localparam logic [4:0] A_TX    = 5'h08;
    localparam logic [4:0] A_RX    = 5'h0C;
    localparam logic [4:0] A_CAUSE = 5'h10;

    typedef struct packed {
        logic [4:0]  n;
        logic        w16;
        logic [15:0] tx;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [4:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        sclk, mosi, miso, cs_n;

    always #10 clk = ~clk;

    mmio_spi_master i_mmio_spi_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .sclk      (sclk),
        .mosi      (mosi),
        .miso      (miso),
        .cs_n      (cs_n)
    );

    int n_chk = 0, n_bad = 0, mon_chk = 0, mon_bad = 0, timeout = 0;
    int cyc = 0;
    int fall_cnt = 0;
    int sl_base = 0, sl_w = 8, sl_k;
    logic [15:0] sl_word = '0;
    exp_t exp_q[$];
    int rd_idx = 0;

    // Free-running cycle count, advanced away from the active edge
    always @(negedge clk) cyc <= cyc + 1;

    // Slave model: next bit is presented after every falling sclk edge
    always @(negedge sclk) fall_cnt <= fall_cnt + 1;
    always_comb begin
        sl_k = sl_w - 1 - (fall_cnt - sl_base);
        miso = (sl_k >= 0 && sl_k < 16) ? sl_word[sl_k[3:0]] : 1'b0;
    end

    // Monitor: rebuild each mosi word at rising edges and time the period
    exp_t cur = '0;
    int   bitk = 0, t0 = 0;
    logic [15:0] cap = '0;
    always @(posedge sclk) begin
        if (bitk == 0) begin
            if (rd_idx >= exp_q.size()) begin
                mon_bad++;
                $display("FAIL R10: unexpected exchange actual=%0d expected=%0d", rd_idx + 1, exp_q.size());
            end else begin
                cur = exp_q[rd_idx];
            end
            t0  = cyc;
            cap = '0;
        end else if (bitk == 1) begin
            mon_chk++;
            if (cyc - t0 != int'(cur.n)) begin
                mon_bad++;
                $display("FAIL R5: sclk period actual=%0d expected=%0d", cyc - t0, cur.n);
            end
        end
        cap  = {cap[14:0], mosi};
        bitk = bitk + 1;
        if (bitk == (cur.w16 ? 16 : 8)) begin
            mon_chk++;
            if ((cur.w16 ? cap : {8'h00, cap[7:0]}) !== (cur.w16 ? cur.tx : {8'h00, cur.tx[7:0]})) begin
                mon_bad++;
                $display("FAIL R4/R6: mosi word actual=%h expected=%h", cap, cur.tx);
            end
            bitk = 0;
            rd_idx++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic int ratio_of(input logic [4:0] p);
        return (p[4] && p[3:0] >= 4'd2) ? 2 * int'(p[3:0]) : 4;
    endfunction

    // Driver: program size/prescale, arm the slave, push the expectation, start
    task automatic xfer(input logic [4:0] p, input logic w16, input logic [15:0] tx,
                        input logic [15:0] sw);
        exp_t e;
        bus_write(A_CFG, {26'd0, w16, p});
        sl_word = sw;
        sl_w    = w16 ? 16 : 8;
        sl_base = fall_cnt;
        e.n = 5'(ratio_of(p)); e.w16 = w16; e.tx = tx;
        exp_q.push_back(e);
        bus_write(A_TX, {16'h0, tx});
    endtask

    task automatic wait_done(input string tag);
        logic [31:0] d = '0;
        for (int i = 0; i < 3000; i++) begin
            bus_read(A_CAUSE, d);
            if (d != 0) break;
        end
        chk(tag, d, 32'h1);
    endtask

    task automatic run_tests();
        logic [31:0] d;
        int k;
        // R1: reset state
        bus_read(A_CTRL, d);  chk("R1 ctrl reset", d, 0);
        bus_read(A_CFG, d);   chk("R1 cfg reset", d, 0);
        bus_read(A_TX, d);    chk("R1 tx reset", d, 0);
        bus_read(A_RX, d);    chk("R1 rx reset", d, 0);
        bus_read(A_CAUSE, d); chk("R1 cause reset", d, 0);
        chk("R1 cs_n reset", {31'd0, cs_n}, 1);
        chk("R1 sclk reset", {31'd0, sclk}, 0);

        // R2: select drive
        bus_write(A_CTRL, 32'h1);
        chk("R2 cs_n asserted", {31'd0, cs_n}, 0);
        bus_read(A_CTRL, d); chk("R2 ctrl readback", d, 1);

        // R3: configuration storage
        bus_write(A_CFG, 32'hFFFF_FFFF);
        bus_read(A_CFG, d); chk("R3 cfg readback", d, 32'h0000_403F);

        // Narrow word at the fastest ratio
        xfer(5'h12, 1'b0, 16'h00A5, 16'h003C);
        wait_done("R8 done narrow");
        bus_read(A_RX, d); chk("R7/R6 rx narrow", d, 32'h3C);
        bus_read(A_TX, d); chk("R4 tx readback", d, 32'hA5);
        bus_write(A_CAUSE, 32'h7);
        bus_read(A_CAUSE, d); chk("R8 nonzero write keeps cause", d, 1);
        bus_write(A_CAUSE, 32'h0);
        bus_read(A_CAUSE, d); chk("R8 zero write clears", d, 0);

        // Wide word at the slowest ratio
        xfer(5'h1F, 1'b1, 16'hBEEF, 16'h1234);
        wait_done("R8 done wide");
        bus_read(A_RX, d); chk("R7/R6 rx wide", d, 32'h1234);
        bus_write(A_CAUSE, 32'h0);

        // Fallback encodings: top bit clear, and a half period below minimum
        xfer(5'h05, 1'b0, 16'h0096, 16'h00C3);
        wait_done("R5 done fallback a");
        bus_read(A_RX, d); chk("R7 rx fallback a", d, 32'hC3);
        bus_write(A_CAUSE, 32'h0);
        xfer(5'h11, 1'b1, 16'h8001, 16'hFFFF);
        wait_done("R5 done fallback b");
        bus_read(A_RX, d); chk("R7 rx fallback b", d, 32'hFFFF);
        bus_write(A_CAUSE, 32'h0);

        // R8: exact completion edge, ratio 6, narrow: K = 48
        k = 48;
        xfer(5'h13, 1'b0, 16'h005A, 16'h0081);
        bus_addr = A_CAUSE;
        repeat (k - 1) @(negedge clk);
        #1 chk("R8 cause clear before edge", bus_rdata, 0);
        @(negedge clk);
        #1 chk("R8 cause set at edge", bus_rdata, 1);
        bus_write(A_CAUSE, 32'h0);

        // R9: clearing write on the completion edge
        xfer(5'h13, 1'b0, 16'h00F0, 16'h000F);
        repeat (k - 2) @(negedge clk);
        bus_write(A_CAUSE, 32'h0);
        bus_read(A_CAUSE, d); chk("R9 set wins over clear", d, 1);
        bus_read(A_RX, d); chk("R9 rx after collision", d, 32'h0F);
        bus_write(A_CAUSE, 32'h0);
        bus_read(A_CAUSE, d); chk("R9 later clear works", d, 0);

        // R10: transmit write while busy, ratio 8, narrow: K = 64
        k = 64;
        xfer(5'h14, 1'b0, 16'h0081, 16'h0066);
        repeat (3) @(negedge clk);
        bus_write(A_TX, 32'h7E);
        bus_addr = A_CAUSE;
        repeat (k - 6) @(negedge clk);
        #1 chk("R10 no early completion", bus_rdata, 0);
        @(negedge clk);
        #1 chk("R10 completion edge kept", bus_rdata, 1);
        bus_read(A_TX, d); chk("R10 tx readback unchanged", d, 32'h81);
        bus_read(A_RX, d); chk("R10 rx of first word", d, 32'h66);
        bus_write(A_CAUSE, 32'h0);

        // R2: release select
        bus_write(A_CTRL, 32'h0);
        chk("R2 cs_n released", {31'd0, cs_n}, 1);

        repeat (40) @(negedge clk);
        chk("R4 all words seen", rd_idx, exp_q.size());
    endtask

    initial begin
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        rst_n = 1'b0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        fork
            run_tests();
            begin
                repeat (150000) @(posedge clk);
                timeout = 1;
                $display("FAIL watchdog: run hung actual=expired expected=finished");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", n_chk + mon_chk + timeout, n_bad + mon_bad + timeout);
        $finish;
    end

endmodule